// File: doc/BRIEF.md
# Function-Coded Arithmetic and Logic Unit with Status Flags

A purely combinational N-bit arithmetic and logic unit. Two operands and a 4-bit function code go in. An N-bit result and four status bits come out.

The arithmetic codes all share one ripple adder. That adder is fed operand A, a selected second addend and a carry-in. The addend is zero, B, the inverse of B, or all ones. Further codes cover bitwise logic, passing either operand through unchanged, and a one-bit shift of operand B in either direction.

The status bits are:
- carry: the adder's carry out, or the bit a shift moves out;
- overflow: signed two's-complement overflow of the addition;
- negative: a copy of the result MSB;
- zero: set when every bit of the result is clear.

Top module: `fs_alu`

## Requirements
- R1: Codes 4'b0000, 4'b0001, 4'b0010 and 4'b0011 give F = A, A+1, A+B and A+B+1 respectively, taken modulo 2^N.
- R2: Code 4'b0100 gives F = A + ~B. Code 4'b0101 gives F = A + ~B + 1, which is A-B. Code 4'b0110 gives F = A-1, formed as A plus an all-ones addend.
- R3: Code 4'b0111 passes A unchanged. Code 4'b1100 passes B unchanged.
- R4: Codes 4'b1000, 4'b1001 and 4'b1010 give bitwise A AND B, A OR B and A XOR B. Code 4'b1011 gives ~A.
- R5: Code 4'b1101 shifts B right by one bit and fills bit N-1 with 0; C equals B[0]. Code 4'b1110 shifts B left by one bit and fills bit 0 with 0; C equals B[N-1]. V is 0 for both codes.
- R6: For every code, Z is 1 exactly when F is all zeros, and N equals F[N-1].
- R7: For codes 4'b0000 to 4'b0110, C is the carry out of the N-bit addition. V is 1 exactly when the signed sum of A, the addend and the carry-in lies outside the N-bit two's-complement range.
- R8: For codes 4'b0111 and 4'b1000 to 4'b1100, C and V are both 0.
- R9: Code 4'b1111 is unused. It drives F to zero with C=0 and V=0, so Z=1 and N=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Operand A |
| b_i | input | N | Operand B |
| fs_i | input | 4 | Function code |
| f_o | output | N | Result |
| c_o | output | 1 | Carry / shifted-out bit |
| v_o | output | 1 | Signed overflow |
| n_o | output | 1 | Negative (result MSB) |
| z_o | output | 1 | Zero result |

## Verification
The in-module checks assume that the operand and function code inputs are settled, known values whenever a check is evaluated. In particular, none of them may carry X or Z bits, because the flag checks compare bit patterns directly.

The stimulus respects this. It changes inputs only on the falling clock edge and compares outputs after the rising edge. Every operand and code it applies comes from a fixed list of boundary values or from a deterministic generator, so every input bit is always driven.

The boundary list is 0, 1, 0x7F, 0x80, 0xFE, 0xFF, 0x55 and 0xAA. Every code is crossed with every pair from that list, so carry and overflow are exercised on both sides of the signed and unsigned wrap.

// File: rtl/fs_alu_pkg.sv
package fs_alu_pkg;
  typedef enum logic [3:0] {
    FN_MOV_A   = 4'b0000,
    FN_INC_A   = 4'b0001,
    FN_ADD     = 4'b0010,
    FN_ADD_C   = 4'b0011,
    FN_ADD_NB  = 4'b0100,
    FN_SUB     = 4'b0101,
    FN_DEC_A   = 4'b0110,
    FN_PASS_A  = 4'b0111,
    FN_AND     = 4'b1000,
    FN_OR      = 4'b1001,
    FN_XOR     = 4'b1010,
    FN_NOT_A   = 4'b1011,
    FN_PASS_B  = 4'b1100,
    FN_SHR_B   = 4'b1101,
    FN_SHL_B   = 4'b1110,
    FN_UNUSED  = 4'b1111
  } fn_e;

  typedef enum logic [1:0] {
    ADDEND_ZERO = 2'd0,
    ADDEND_B    = 2'd1,
    ADDEND_NB   = 2'd2,
    ADDEND_ONES = 2'd3
  } addend_e;
endpackage

// File: rtl/fs_alu_adder.sv
module fs_alu_adder #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         cin_i,
  output logic [N-1:0] s_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [N:0] carry;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign s_o[i]       = x_i[i] ^ y_i[i] ^ carry[i];
    assign carry[i+1]   = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
  end

  assign cout_o = carry[N];
  assign ovf_o  = carry[N] ^ carry[N-1];

  always_comb begin
    assert_sum_R7: assert ({cout_o, s_o} == ({1'b0, x_i} + {1'b0, y_i} + {{N{1'b0}}, cin_i}))
      else $error("adder sum/carry mismatch");
    assert_ovf_R7: assert (ovf_o == ((x_i[N-1] == y_i[N-1]) && (s_o[N-1] != x_i[N-1])))
      else $error("adder overflow mismatch");
  end
endmodule

// File: rtl/fs_alu_logic.sv
module fs_alu_logic
  import fs_alu_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [3:0]   fs_i,
  output logic [N-1:0] r_o
);
  always_comb begin
    unique case (fs_i)
      FN_AND:    r_o = a_i & b_i;
      FN_OR:     r_o = a_i | b_i;
      FN_XOR:    r_o = a_i ^ b_i;
      FN_NOT_A:  r_o = ~a_i;
      FN_PASS_B: r_o = b_i;
      default:   r_o = a_i;
    endcase
  end
endmodule

// File: rtl/fs_alu_shift.sv
module fs_alu_shift #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] b_i,
  input  logic         left_i,
  output logic [N-1:0] r_o,
  output logic         out_bit_o
);
  always_comb begin
    if (left_i) begin
      r_o       = {b_i[N-2:0], 1'b0};
      out_bit_o = b_i[N-1];
    end else begin
      r_o       = {1'b0, b_i[N-1:1]};
      out_bit_o = b_i[0];
    end
  end

  always_comb begin
    assert_fill_R5: assert (left_i ? (r_o[0] == 1'b0) : (r_o[N-1] == 1'b0))
      else $error("shift fill bit not zero");
    assert_outbit_R5: assert (left_i ? ((r_o >> 1) == (b_i & {1'b0, {(N-1){1'b1}}}))
                                     : ((r_o << 1) == (b_i & {{(N-1){1'b1}}, 1'b0})))
      else $error("shift data mismatch");
  end
endmodule

// File: rtl/fs_alu.sv
module fs_alu
  import fs_alu_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [3:0]   fs_i,
  output logic [N-1:0] f_o,
  output logic         c_o,
  output logic         v_o,
  output logic         n_o,
  output logic         z_o
);
  localparam int unsigned MSB = N - 1;

  addend_e     addend_sel;
  logic        add_cin;
  logic [N-1:0] addend;
  logic [N-1:0] add_sum, logic_res, shift_res;
  logic        add_cout, add_ovf, shift_out;

  always_comb begin
    add_cin = 1'b0;
    unique case (fs_i)
      FN_MOV_A:  addend_sel = ADDEND_ZERO;
      FN_INC_A:  begin addend_sel = ADDEND_ZERO; add_cin = 1'b1; end
      FN_ADD:    addend_sel = ADDEND_B;
      FN_ADD_C:  begin addend_sel = ADDEND_B; add_cin = 1'b1; end
      FN_ADD_NB: addend_sel = ADDEND_NB;
      FN_SUB:    begin addend_sel = ADDEND_NB; add_cin = 1'b1; end
      FN_DEC_A:  addend_sel = ADDEND_ONES;
      default:   addend_sel = ADDEND_ZERO;
    endcase
  end

  always_comb begin
    unique case (addend_sel)
      ADDEND_B:    addend = b_i;
      ADDEND_NB:   addend = ~b_i;
      ADDEND_ONES: addend = '1;
      default:     addend = '0;
    endcase
  end

  fs_alu_adder #(.N(N)) u_add (
    .x_i(a_i), .y_i(addend), .cin_i(add_cin),
    .s_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  fs_alu_logic #(.N(N)) u_logic (
    .a_i(a_i), .b_i(b_i), .fs_i(fs_i), .r_o(logic_res)
  );

  fs_alu_shift #(.N(N)) u_shift (
    .b_i(b_i), .left_i(fs_i == FN_SHL_B), .r_o(shift_res), .out_bit_o(shift_out)
  );

  // fs_i[3]==0 and not 0111 selects the adder path
  logic is_arith, is_shift, is_unused;
  assign is_arith  = !fs_i[3] && (fs_i != FN_PASS_A);
  assign is_shift  = (fs_i == FN_SHR_B) || (fs_i == FN_SHL_B);
  assign is_unused = (fs_i == FN_UNUSED);

  always_comb begin
    if (is_arith) begin
      f_o = add_sum;   c_o = add_cout;  v_o = add_ovf;
    end else if (is_shift) begin
      f_o = shift_res; c_o = shift_out; v_o = 1'b0;
    end else if (is_unused) begin
      f_o = '0;        c_o = 1'b0;      v_o = 1'b0;
    end else begin
      f_o = logic_res; c_o = 1'b0;      v_o = 1'b0;
    end
  end

  assign n_o = f_o[MSB];
  assign z_o = (f_o == '0);

  always_comb begin
    assert_quiet_flags_R8: assert (is_arith || is_shift || (!c_o && !v_o))
      else $error("carry/overflow set on logic code");
    assert_unused_R9: assert (!is_unused || (z_o && !n_o && !c_o && !v_o))
      else $error("unused code not idle");
    assert_shift_no_ovf_R5: assert (!is_shift || !v_o)
      else $error("overflow set on shift");
    assert_zero_flag_R6: assert (z_o == ($countones(f_o) == 0))
      else $error("zero flag mismatch");
  end
endmodule

// File: tb/sim_fs_alu.sv
module sim_fs_alu;
  localparam int N = 8;
  localparam int MASK = (1 << N) - 1;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] a, b, f;
  logic [3:0] fs;
  logic c, v, nf, z;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fs_alu #(.N(N)) u0 (
    .a_i(a), .b_i(b), .fs_i(fs),
    .f_o(f), .c_o(c), .v_o(v), .n_o(nf), .z_o(z)
  );

  function automatic string req_of(int code);
    if (code <= 3)  return "R1/R6/R7";
    if (code <= 6)  return "R2/R6/R7";
    if (code == 7 || code == 12) return "R3/R6/R8";
    if (code <= 11) return "R4/R6/R8";
    if (code <= 14) return "R5/R6";
    return "R9";
  endfunction

  function automatic int sgn(int x);
    return (x >= (1 << (N-1))) ? x - (1 << N) : x;
  endfunction

  // returns {v, c, f}
  function automatic int model(int ai, int bi, int code);
    int y, cin, r, cc, vv, sres;
    cc = 0; vv = 0; y = 0; cin = 0;
    if (code <= 6) begin
      case (code)
        1: cin = 1;
        2: y = bi;
        3: begin y = bi; cin = 1; end
        4: y = (~bi) & MASK;
        5: begin y = (~bi) & MASK; cin = 1; end
        6: y = MASK;
        default: ;
      endcase
      r = ai + y + cin;
      cc = (r >> N) & 1;
      r = r & MASK;
      sres = sgn(ai) + sgn(y) + cin;
      vv = (sres > (1 << (N-1)) - 1 || sres < -(1 << (N-1))) ? 1 : 0;
    end else begin
      case (code)
        7:  r = ai;
        8:  r = ai & bi;
        9:  r = ai | bi;
        10: r = ai ^ bi;
        11: r = (~ai) & MASK;
        12: r = bi;
        13: begin r = bi >> 1; cc = bi & 1; end
        14: begin r = (bi << 1) & MASK; cc = (bi >> (N-1)) & 1; end
        default: r = 0;
      endcase
    end
    return (vv << (N+1)) | (cc << N) | r;
  endfunction

  task automatic apply(int ai, int bi, int code);
    int exp, ef, ec, ev, en, ez;
    @(negedge clk);
    a = ai[N-1:0]; b = bi[N-1:0]; fs = code[3:0];
    @(posedge clk);
    #2;
    exp = model(ai, bi, code);
    ef = exp & MASK; ec = (exp >> N) & 1; ev = (exp >> (N+1)) & 1;
    en = (ef >> (N-1)) & 1; ez = (ef == 0) ? 1 : 0;
    checks++;
    if (int'(f) != ef || int'(c) != ec || int'(v) != ev || int'(nf) != en || int'(z) != ez) begin
      fails++;
      $display("FAIL %s fs=%0d a=%02h b=%02h: got f=%02h c%0d v%0d n%0d z%0d exp f=%02h c%0d v%0d n%0d z%0d",
               req_of(code), code, ai, bi, f, c, v, nf, z, ef, ec, ev, en, ez);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int edge_v [8] = '{0, 1, 'h7f, 'h80, 'hfe, 'hff, 'h55, 'haa};
    bit [31:0] seed = 32'h1234_5678;
    a = '0; b = '0; fs = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state vector: all inputs zero, expects F=0, Z=1 (R1, R6)
    apply(0, 0, 0);
    // directed corners
    apply('h7f, 0, 1);    // R7 overflow on increment
    apply('hff, 0, 1);    // R7 carry on increment
    apply('h80, 0, 6);    // R2 A-1 overflow
    apply(0, 0, 6);       // R2 A-1 no carry
    apply('h80, 1, 5);    // R2 subtraction overflow
    apply('h81, 'h01, 13); // R5 right shift carry
    apply('h81, 'h81, 14); // R5 left shift carry
    apply('h5a, 'h3c, 15); // R9 unused
    apply('h5a, 'h3c, 7);  // R3 pass A
    apply('h5a, 'h3c, 12); // R3 pass B
    apply('hff, 'hff, 11); // R4 complement to zero
    for (int code = 0; code < 16; code++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(edge_v[i], edge_v[j], code);
    for (int k = 0; k < 2000; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      apply(int'(seed[23:16]), int'(seed[15:8]), int'(seed[7:4]));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule